// File: doc/BRIEF.md
# Character Display Start-up and Text Sequencer

This block brings up a 16x2 character display that has an 8-bit parallel bus and then prints a fixed four-letter word on it. It has no input other than the clock and an asynchronous active-low reset. After reset it steps through eight bus transfers, one at a time. The first four are configuration commands and the last four are character codes.

Each transfer has three phases. In the setup phase the byte and the register-select level go onto the bus while the enable strobe stays low. In the strobe phase the enable is high. In the gap phase the enable is low again and the bus is held. Every phase length is a whole number of clock cycles. The strobe length is derived from the clock period so that it always covers the display's minimum enable width.

When the last character has been strobed, the sequencer parks. The enable stays low and the bus keeps its last value until the next reset. There is no busy-flag polling and no way to send a command while the block is running.

Top module: `lcd_seq_top`

## Requirements
- R1: The four command transfers come first, with register-select at 0, in this order: 0x38, 0x01, 0x06, 0x0C.
- R2: The four character transfers follow, with register-select at 1, in this order: 0x53, 0x48, 0x52, 0x49.
- R3: During every enable pulse, register-select is 0 for the four command transfers and 1 for the four character transfers.
- R4: The read/write line `lcd_rw` is 0 at all times.
- R5: Every enable pulse lasts exactly E_HIGH_CYC = ceil(E_MIN_NS / CLK_PERIOD_NS) cycles. With the defaults this is ceil(450/20) = 23 cycles, which is at least 450 ns.
- R6: Data and register-select hold their values for SETUP_CYC (at least 1) cycles before the enable rises. They are also unchanged in the cycle after the enable falls.
- R7: After a fall of the enable, the enable stays low for GAP_CYC + SETUP_CYC cycles before the next rise. One transfer therefore takes SETUP_CYC + E_HIGH_CYC + GAP_CYC cycles.
- R8: After the eighth transfer the enable stays low for good. With IDLE_ZERO_BUS = 0 the bus keeps 0x49 and register-select keeps 1; with IDLE_ZERO_BUS = 1 the bus reads 0x00.
- R9: While reset is low, the enable is 0, the bus shows 0x38 and register-select is 0. Releasing reset, even in the middle of the sequence, starts again from the first command in setup phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all phase lengths count its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sequence |
| lcd_data | output | 8 | Parallel byte for the display |
| lcd_rs | output | 1 | Register select: 0 for a command, 1 for a character |
| lcd_rw | output | 1 | Read/write select, held at 0 (write) |
| lcd_en | output | 1 | Enable strobe; the display latches on its falling edge |

## Verification
A wrong transfer index shows up at once on `lcd_data` and `lcd_rs`. It appears from the first setup cycle of the affected transfer, so the byte order is checked in every cycle, not only at the strobe. A wrong phase state or counter load moves the next enable edge, so a one-cycle error in any phase length appears at the very next edge of `lcd_en`, and every later edge is shifted too. A missed terminal condition appears as a ninth enable pulse about one transfer period after the eighth.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   localparam int N_CMD  = 4;
   localparam int N_CHR  = 4;
   localparam int N_XFER = N_CMD + N_CHR;
   localparam int STEP_W = $clog2(N_XFER);

   // one-hot phase code; idle is all-zero so the strobe is a single flop bit
   typedef enum logic [2:0] {
      PH_IDLE  = 3'b000,
      PH_SETUP = 3'b001,
      PH_PULSE = 3'b010,
      PH_GAP   = 3'b100
   } lcd_phase_e;

   typedef struct packed {
      logic [7:0] code;
      logic       is_char;
   } lcd_xfer_t;

endpackage

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
   import lcd_seq_pkg::*;
(
   input  logic [STEP_W-1:0] step,
   output lcd_xfer_t         xfer
);

   always_comb begin
      xfer.is_char = (int'(step) >= N_CMD);
      unique case (step)
         3'd0:    xfer.code = 8'h38;
         3'd1:    xfer.code = 8'h01;
         3'd2:    xfer.code = 8'h06;
         3'd3:    xfer.code = 8'h0C;
         3'd4:    xfer.code = 8'h53;
         3'd5:    xfer.code = 8'h48;
         3'd6:    xfer.code = 8'h52;
         default: xfer.code = 8'h49;
      endcase
   end

endmodule

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain_q <= CNT_W'(RST_VAL);
      else if (load)
         remain_q <= load_val;
      else if (remain_q != '0)
         remain_q <= remain_q - 1'b1;
   end

   assign expired = (remain_q == '0);

endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
   import lcd_seq_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int SETUP_CYC  = 1,
   parameter int E_HIGH_CYC = 1,
   parameter int GAP_CYC    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              expired,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output lcd_phase_e        phase,
   output logic [STEP_W-1:0] step
);

   localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(E_HIGH_CYC - 1);
   localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(GAP_CYC - 1);
   localparam logic [STEP_W-1:0] LAST   = STEP_W'(N_XFER - 1);

   lcd_phase_e        phase_q, phase_d;
   logic [STEP_W-1:0] step_q, step_d;

   always_comb begin
      phase_d  = phase_q;
      step_d   = step_q;
      load     = 1'b0;
      load_val = '0;
      unique case (phase_q)
         PH_SETUP: if (expired) begin
            phase_d  = PH_PULSE;
            load     = 1'b1;
            load_val = LD_PULSE;
         end
         PH_PULSE: if (expired) begin
            phase_d  = PH_GAP;
            load     = 1'b1;
            load_val = LD_GAP;
         end
         PH_GAP: if (expired) begin
            if (step_q == LAST) begin
               phase_d = PH_IDLE;
            end else begin
               phase_d  = PH_SETUP;
               step_d   = step_q + 1'b1;
               load     = 1'b1;
               load_val = LD_SETUP;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_SETUP;
         step_q  <= '0;
      end else begin
         phase_q <= phase_d;
         step_q  <= step_d;
      end
   end

   assign phase = phase_q;
   assign step  = step_q;

endmodule

// File: rtl/lcd_seq_top.sv
module lcd_seq_top
   import lcd_seq_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 20,
   parameter int E_MIN_NS      = 450,
   parameter int SETUP_CYC     = 2,
   parameter int GAP_CYC       = 40,
   parameter bit IDLE_ZERO_BUS = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [7:0] lcd_data,
   output logic       lcd_rs,
   output logic       lcd_rw,
   output logic       lcd_en
);

   localparam int E_HIGH_CYC = (E_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
   localparam int MAX_A      = (E_HIGH_CYC > GAP_CYC) ? E_HIGH_CYC : GAP_CYC;
   localparam int MAX_CYC    = (MAX_A > SETUP_CYC) ? MAX_A : SETUP_CYC;
   localparam int CNT_W      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   if (CLK_PERIOD_NS < 1) begin : g_bad_period
      $error("lcd_seq_top: CLK_PERIOD_NS must be positive");
   end
   if (E_MIN_NS < 1) begin : g_bad_width
      $error("lcd_seq_top: E_MIN_NS must be positive");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("lcd_seq_top: SETUP_CYC must be at least 1");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("lcd_seq_top: GAP_CYC must be at least 1");
   end

   logic              expired;
   logic              load;
   logic [CNT_W-1:0]  load_val;
   lcd_phase_e        phase;
   logic [STEP_W-1:0] step;
   lcd_xfer_t         xfer;

   lcd_seq_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (SETUP_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   lcd_seq_fsm #(
      .CNT_W      (CNT_W),
      .SETUP_CYC  (SETUP_CYC),
      .E_HIGH_CYC (E_HIGH_CYC),
      .GAP_CYC    (GAP_CYC)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .expired  (expired),
      .load     (load),
      .load_val (load_val),
      .phase    (phase),
      .step     (step)
   );

   lcd_seq_rom u_rom (
      .step (step),
      .xfer (xfer)
   );

   // strobe comes straight from the one-hot pulse bit: no decode glitch
   assign lcd_en = phase[1];
   assign lcd_rw = 1'b0;
   assign lcd_rs = xfer.is_char;

   if (IDLE_ZERO_BUS) begin : g_idle_zero
      assign lcd_data = (phase == PH_IDLE) ? 8'h00 : xfer.code;
   end else begin : g_idle_hold
      assign lcd_data = xfer.code;
   end

endmodule

// File: rtl/lcd_seq_chk.sv
module lcd_seq_chk #(
   parameter int E_HIGH_CYC = 1,
   parameter int N_CMD      = 4,
   parameter int N_XFER     = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] lcd_data,
   input logic       lcd_rs,
   input logic       lcd_rw,
   input logic       lcd_en
);

   logic [15:0] hi_run;
   logic [3:0]  rises;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
         rises  <= '0;
      end else begin
         hi_run <= lcd_en ? hi_run + 1'b1 : '0;
         if (lcd_en && hi_run == '0 && rises != 4'hF)
            rises <= rises + 1'b1;
      end
   end

   p_rw_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_rw == 1'b0);

   p_width_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_en) |-> hi_run == 16'(E_HIGH_CYC));

   p_setup_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_en |-> ($stable(lcd_data) && $stable(lcd_rs)));

   p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_en) |-> ($stable(lcd_data) && $stable(lcd_rs)));

   p_rs_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_en && hi_run == '0) |-> (lcd_rs == (int'(rises) >= N_CMD)));

   p_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rises) >= N_XFER && !lcd_en) |=> !lcd_en);

endmodule

bind lcd_seq_top lcd_seq_chk #(
   .E_HIGH_CYC (E_HIGH_CYC),
   .N_CMD      (lcd_seq_pkg::N_CMD),
   .N_XFER     (lcd_seq_pkg::N_XFER)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lcd_data (lcd_data),
   .lcd_rs   (lcd_rs),
   .lcd_rw   (lcd_rw),
   .lcd_en   (lcd_en)
);

// File: tb/sim_lcd_seq_top.sv
module sim_lcd_seq_top;

   localparam int TB_CLK_NS = 50;
   localparam int SETUP     = 2;
   localparam int GAP       = 5;
   localparam int EMIN      = 450;
   localparam int EH        = (EMIN + TB_CLK_NS - 1) / TB_CLK_NS;
   localparam int PER       = SETUP + EH + GAP;
   localparam int NX        = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] lcd_data;
   logic       lcd_rs, lcd_rw, lcd_en;

   int n_run = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(TB_CLK_NS/2) clk = ~clk;

   lcd_seq_top #(
      .CLK_PERIOD_NS (TB_CLK_NS),
      .E_MIN_NS      (EMIN),
      .SETUP_CYC     (SETUP),
      .GAP_CYC       (GAP),
      .IDLE_ZERO_BUS (1'b0)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .lcd_data (lcd_data),
      .lcd_rs   (lcd_rs),
      .lcd_rw   (lcd_rw),
      .lcd_en   (lcd_en)
   );

   function automatic logic [7:0] code_of(int i);
      case (i)
         0: return 8'h38;
         1: return 8'h01;
         2: return 8'h06;
         3: return 8'h0C;
         4: return 8'h53;
         5: return 8'h48;
         6: return 8'h52;
         default: return 8'h49;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // t counts falling edges since reset was released (t = 0 at release)
   task automatic sweep(int ncyc);
      for (int t = 0; t < ncyc; t++) begin
         int  idx, ph;
         bit  ee;
         if (t < NX * PER) begin
            idx = t / PER;
            ph  = t % PER;
            ee  = (ph >= SETUP) && (ph < SETUP + EH);
         end else begin
            idx = NX - 1;
            ee  = 1'b0;
         end
         if (t >= NX * PER) chk("R8 enable parked", int'(lcd_en), 0);
         else chk("R5/R7 enable timing", int'(lcd_en), int'(ee));
         if (idx < 4) chk("R1 command byte", int'(lcd_data), int'(code_of(idx)));
         else chk("R2 character byte", int'(lcd_data), int'(code_of(idx)));
         chk("R3 register select", int'(lcd_rs), (idx >= 4) ? 1 : 0);
         chk("R4 rw low", int'(lcd_rw), 0);
         @(negedge clk);
      end
   endtask

   task automatic check_reset_state();
      chk("R9 reset enable", int'(lcd_en), 0);
      chk("R9 reset data", int'(lcd_data), 8'h38);
      chk("R9 reset rs", int'(lcd_rs), 0);
   endtask

   // R6: byte held for SETUP cycles before rise and one cycle after fall
   int rise_seen = 0;
   int pulse_len = 0;
   logic [7:0] prev_data;
   logic       prev_en = 1'b0;
   int         stable_run = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (lcd_en && !prev_en) begin
            chk("R6 setup cycles before rise", (stable_run >= SETUP) ? 1 : 0, 1);
            rise_seen++;
         end
         if (!lcd_en && prev_en) begin
            chk("R6 hold after fall", int'(lcd_data), int'(prev_data));
            chk("R5 pulse width", pulse_len, EH);
         end
         pulse_len  = lcd_en ? pulse_len + 1 : 0;
         stable_run = (lcd_data === prev_data) ? stable_run + 1 : 1;
      end else begin
         pulse_len  = 0;
         stable_run = 1;
      end
      prev_en   = lcd_en;
      prev_data = lcd_data;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state();
      chk("R5 ceil width param", EH, 9);
      rst_n = 1'b1;
      sweep(NX * PER + 30);
      chk("R8 exactly eight strobes", rise_seen, NX);

      // R9: reset in the middle of a character strobe, then full rerun
      rst_n = 1'b0;
      @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      sweep(5 * PER + SETUP + 3);
      rst_n = 1'b0;
      @(negedge clk);
      check_reset_state();
      @(negedge clk);
      rise_seen = 0;
      rst_n = 1'b1;
      sweep(NX * PER + 20);
      chk("R9 restart yields eight strobes", rise_seen, NX);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      #(TB_CLK_NS * 200000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

endmodule